// File: doc/BRIEF.md
# Iterative Decoder Phase Sequencer

This block is the top-level sequencer of an iterative belief-propagation decoder. On a start request it has the input buffer loaded, runs an initialisation pass that seeds the channel likelihoods, and then alternates check-node and variable-node update passes. The datapath units that do the actual work are external. Each pass is launched with a one-cycle start pulse, and the sequencer waits for that pass's done strobe before it moves on.

The sequencer runs a fixed number of iterations and never stops early. Once the last iteration has finished, it streams the hard decisions out of the output buffer. It does this by holding a read enable and stepping a read address by one every cycle. After the final address has been presented it raises a completion flag. The flag stays high until the next start request is accepted. A start request that arrives while a decode is in progress is discarded.

Top module: `iter_dec_seq`

## Requirements
- R1: A synchronous active-high reset, applied at any point, leaves all phase start pulses, `rd_en_o` and `done_o` low, and both `iter_o` and `rd_addr_o` at 0.
- R2: When idle or finished, a high `start_i` sampled on a clock edge produces `load_start_o` high for exactly the following cycle, and `done_o` is low from that cycle on.
- R3: The passes run in a fixed order: load, then initialisation, then check-node update, then variable-node update. Each pass's start pulse follows the done strobe of the pass before it, lasts one cycle, and no two start pulses are ever high together.
- R4: `iter_o` reads 1 when the first check-node pulse is issued and rises by one with each later check-node pulse. Exactly `MAX_ITER` check-node pulses and `MAX_ITER` variable-node pulses occur per decode, with default `MAX_ITER` = 10.
- R5: A done strobe for a pass other than the one being waited on has no effect: no start pulse follows it.
- R6: `rd_en_o` rises only after the variable-node pass of iteration `MAX_ITER` is done. It then stays high for exactly `CODE_LEN` consecutive cycles, and `rd_addr_o` counts 0, 1, …, `CODE_LEN`-1 over those cycles.
- R7: `done_o` goes high in the cycle after the last read and stays high, with `rd_en_o` low, until a new start is accepted.
- R8: `start_i` asserted while a decode is in progress is ignored: no load pulse is issued and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a decode |
| load_start_o | output | 1 | One-cycle pulse launching the input-buffer load |
| load_done_i | input | 1 | Input-buffer load finished |
| init_start_o | output | 1 | One-cycle pulse launching likelihood initialisation |
| init_done_i | input | 1 | Initialisation finished |
| cn_start_o | output | 1 | One-cycle pulse launching a check-node update pass |
| cn_done_i | input | 1 | Check-node pass finished |
| vn_start_o | output | 1 | One-cycle pulse launching a variable-node update pass |
| vn_done_i | input | 1 | Variable-node pass finished |
| iter_o | output | $clog2(MAX_ITER+1) | Current iteration number (0 before the first pass) |
| rd_en_o | output | 1 | Output-buffer read enable |
| rd_addr_o | output | $clog2(CODE_LEN) | Output-buffer read address |
| done_o | output | 1 | Decode complete; all decisions read |

## Verification
Full decodes are driven with several sets of per-pass response latencies. These range from done strobes that return in the same cycle as the start pulse to strobes that arrive several cycles later. Zero-latency runs show whether back-to-back transitions drop or merge pulses, and long-latency runs show whether the sequencer really waits for each done strobe. Some runs inject a stray variable-node done strobe and a second start request in the middle of a check-node pass, which separates a sequencer that listens only to the awaited strobe from one that reacts to any strobe. Reset in the middle of a run and done strobes sent while idle cover recovery and the ignore behaviour.

// File: rtl/iter_seq_pkg.sv
package iter_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_INIT,
        ST_CNU,
        ST_VNU,
        ST_CHK,
        ST_OUT,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic load;
        logic init;
        logic cn;
        logic vn;
    } phase_vec_t;

endpackage

// File: rtl/iter_seq_fsm.sv
module iter_seq_fsm
    import iter_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  phase_vec_t done_i,
    input  logic       last_iter_i,
    input  logic       last_addr_i,
    output seq_state_t state_o,
    output phase_vec_t pulse_o,
    output logic       iter_clr_o,
    output logic       iter_first_o,
    output logic       iter_step_o
);

    seq_state_t state_q, state_d;
    phase_vec_t pulse_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)         state_d = ST_LOAD;
            ST_LOAD: if (done_i.load)     state_d = ST_INIT;
            ST_INIT: if (done_i.init)     state_d = ST_CNU;
            ST_CNU:  if (done_i.cn)       state_d = ST_VNU;
            ST_VNU:  if (done_i.vn)       state_d = ST_CHK;
            ST_CHK:  state_d = last_iter_i ? ST_OUT : ST_CNU;
            ST_OUT:  if (last_addr_i)     state_d = ST_DONE;
            ST_DONE: if (start_i)         state_d = ST_LOAD;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
        end else begin
            state_q      <= state_d;
            pulse_q.load <= (state_d == ST_LOAD) && (state_q != ST_LOAD);
            pulse_q.init <= (state_d == ST_INIT) && (state_q != ST_INIT);
            pulse_q.cn   <= (state_d == ST_CNU)  && (state_q != ST_CNU);
            pulse_q.vn   <= (state_d == ST_VNU)  && (state_q != ST_VNU);
        end
    end

    assign state_o      = state_q;
    assign pulse_o      = pulse_q;
    assign iter_clr_o   = (state_q != ST_LOAD) && (state_d == ST_LOAD);
    assign iter_first_o = (state_q == ST_INIT) && (state_d == ST_CNU);
    assign iter_step_o  = (state_q == ST_CHK)  && (state_d == ST_CNU);

    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulse_q.load, pulse_q.init, pulse_q.cn, pulse_q.vn}));

    // R3
    cn_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.cn |=> !pulse_q.cn);

    // R3
    vn_after_cn_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q.vn) |-> $past(done_i.cn));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> !pulse_q.load);

endmodule

// File: rtl/iter_seq_iter_cnt.sv
module iter_seq_iter_cnt #(
    parameter int MAX_ITER = 10,
    parameter int IW       = $clog2(MAX_ITER + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          first_i,
    input  logic          step_i,
    output logic [IW-1:0] iter_o,
    output logic          last_o
);

    localparam logic [IW-1:0] ITER_TOP = IW'(MAX_ITER);

    logic [IW-1:0] iter_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)   iter_q <= '0;
        else if (first_i)   iter_q <= IW'(1);
        else if (step_i)    iter_q <= iter_q + 1'b1;
    end

    assign iter_o = iter_q;
    assign last_o = (iter_q == ITER_TOP);

    // R4
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        iter_q <= ITER_TOP);

    // R4
    iter_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |=> iter_q == $past(iter_q) + 1'b1);

endmodule

// File: rtl/iter_seq_rd_cnt.sv
module iter_seq_rd_cnt #(
    parameter int CODE_LEN = 16,
    parameter int AW       = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);

    localparam logic [AW-1:0] ADDR_TOP = AW'(CODE_LEN - 1);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (en_i)
            addr_q <= (addr_q == ADDR_TOP) ? '0 : addr_q + 1'b1;
    end

    assign addr_o = addr_q;
    assign last_o = (addr_q == ADDR_TOP);

    // R6
    addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && addr_q != ADDR_TOP) |=> en_i && (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/iter_dec_seq.sv
module iter_dec_seq
    import iter_seq_pkg::*;
#(
    parameter int MAX_ITER = 10,
    parameter int CODE_LEN = 16,
    localparam int IW      = $clog2(MAX_ITER + 1),
    localparam int AW      = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic          load_start_o,
    input  logic          load_done_i,
    output logic          init_start_o,
    input  logic          init_done_i,
    output logic          cn_start_o,
    input  logic          cn_done_i,
    output logic          vn_start_o,
    input  logic          vn_done_i,
    output logic [IW-1:0] iter_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          done_o
);

    seq_state_t state;
    phase_vec_t dones, pulses;
    logic       iter_clr, iter_first, iter_step, last_iter, last_addr;

    assign dones = '{load: load_done_i, init: init_done_i, cn: cn_done_i, vn: vn_done_i};

    iter_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .done_i       (dones),
        .last_iter_i  (last_iter),
        .last_addr_i  (last_addr),
        .state_o      (state),
        .pulse_o      (pulses),
        .iter_clr_o   (iter_clr),
        .iter_first_o (iter_first),
        .iter_step_o  (iter_step)
    );

    iter_seq_iter_cnt #(.MAX_ITER(MAX_ITER), .IW(IW)) u_iter (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (iter_clr),
        .first_i (iter_first),
        .step_i  (iter_step),
        .iter_o  (iter_o),
        .last_o  (last_iter)
    );

    iter_seq_rd_cnt #(.CODE_LEN(CODE_LEN), .AW(AW)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .en_i   (rd_en_o),
        .addr_o (rd_addr_o),
        .last_o (last_addr)
    );

    assign load_start_o = pulses.load;
    assign init_start_o = pulses.init;
    assign cn_start_o   = pulses.cn;
    assign vn_start_o   = pulses.vn;
    assign rd_en_o      = (state == ST_OUT);
    assign done_o       = (state == ST_DONE);

    // R6
    rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> iter_o == IW'(MAX_ITER));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o && !rd_en_o);

    // R2
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> !done_o && load_start_o);

endmodule

// File: tb/iter_dec_seq_test.sv
module iter_dec_seq_test;

    localparam int MAXI = 10;
    localparam int N    = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       load_done_i = 1'b0, init_done_i = 1'b0, cn_done_i = 1'b0, vn_done_i = 1'b0;
    logic       load_start_o, init_start_o, cn_start_o, vn_start_o;
    logic [3:0] iter_o;
    logic       rd_en_o, done_o;
    logic [3:0] rd_addr_o;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    int cn_cnt = 0, vn_cnt = 0, early_rd = 0;

    // fields: load/init latency, check-node latency, variable-node latency, stray injection
    localparam int unsigned VEC [4][4] = '{
        '{0, 0, 0, 0},
        '{1, 2, 3, 0},
        '{3, 0, 5, 1},
        '{2, 4, 1, 1}
    };

    iter_dec_seq #(.MAX_ITER(MAXI), .CODE_LEN(N)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .load_start_o(load_start_o), .load_done_i(load_done_i),
        .init_start_o(init_start_o), .init_done_i(init_done_i),
        .cn_start_o(cn_start_o), .cn_done_i(cn_done_i),
        .vn_start_o(vn_start_o), .vn_done_i(vn_done_i),
        .iter_o(iter_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cn_start_o) cn_cnt = cn_cnt + 1;
        if (vn_start_o) vn_cnt = vn_cnt + 1;
        if (rd_en_o && iter_o != 4'(MAXI)) early_rd = early_rd + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pulse_of(input int which);
        case (which)
            0: return load_start_o;
            1: return init_start_o;
            2: return cn_start_o;
            default: return vn_start_o;
        endcase
    endfunction

    task automatic set_done(input int which, input logic v);
        case (which)
            0: load_done_i = v;
            1: init_done_i = v;
            2: cn_done_i   = v;
            default: vn_done_i = v;
        endcase
    endtask

    task automatic run_phase(input int which, input int lat, input int kiter, input bit stray);
        bit seen = 0;
        for (int t = 0; t < 50; t++) begin
            if (pulse_of(which)) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, "R3 start pulse issued", seen, 1);
        if (which == 2) chk(iter_o == 4'(kiter), "R4 iteration number", iter_o, kiter);
        if (stray) begin
            vn_done_i = 1'b1; start_i = 1'b1;
            @(negedge clk);
            vn_done_i = 1'b0; start_i = 1'b0;
            chk(vn_start_o == 1'b0, "R5 stray done ignored", vn_start_o, 0);
            chk(load_start_o == 1'b0, "R8 busy start ignored", load_start_o, 0);
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            if (i == 0) chk(pulse_of(which) == 1'b0, "R3 pulse width", pulse_of(which), 0);
        end
        set_done(which, 1'b1);
        @(negedge clk);
        set_done(which, 1'b0);
    endtask

    task automatic do_run(input int l0, input int l1, input int l2, input bit stray);
        int cn0, vn0, idx;
        bit got;
        cn0 = cn_cnt; vn0 = vn_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(load_start_o == 1'b1, "R2 load pulse", load_start_o, 1);
        chk(done_o == 1'b0, "R2 done cleared", done_o, 0);
        run_phase(0, l0, 0, 0);
        run_phase(1, l0, 0, 0);
        for (int k = 1; k <= MAXI; k++) begin
            run_phase(2, l1, k, stray && (k == 3));
            run_phase(3, l2, k, 0);
        end
        got = 0;
        for (int t = 0; t < 10; t++) begin
            if (rd_en_o) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "R6 readout begins", got, 1);
        idx = 0;
        while (rd_en_o && idx < N + 4) begin
            chk(rd_addr_o == 4'(idx), "R6 read address", rd_addr_o, idx);
            idx++;
            @(negedge clk);
        end
        chk(idx == N, "R6 read count", idx, N);
        chk(cn_cnt - cn0 == MAXI, "R4 check-node passes", cn_cnt - cn0, MAXI);
        chk(vn_cnt - vn0 == MAXI, "R4 variable-node passes", vn_cnt - vn0, MAXI);
        chk(early_rd == 0, "R6 read before last iteration", early_rd, 0);
        for (int h = 0; h < 3; h++) begin
            chk(done_o == 1'b1 && rd_en_o == 1'b0, "R7 completion held", done_o, 1);
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk(load_start_o == 0 && cn_start_o == 0 && rd_en_o == 0, "R1 reset outputs", rd_en_o, 0);
        chk(done_o == 0 && iter_o == 0 && rd_addr_o == 0, "R1 reset counters", iter_o, 0);
        rst = 1'b0;
        @(negedge clk);

        // R5: done strobes while idle
        cn_done_i = 1'b1; vn_done_i = 1'b1; load_done_i = 1'b1;
        @(negedge clk);
        cn_done_i = 1'b0; vn_done_i = 1'b0; load_done_i = 1'b0;
        chk(init_start_o == 0 && cn_start_o == 0 && vn_start_o == 0, "R5 idle strobes ignored",
            cn_start_o, 0);

        for (int v = 0; v < 4; v++)
            do_run(int'(VEC[v][0]), int'(VEC[v][1]), int'(VEC[v][2]), VEC[v][3] != 0);

        // R1: reset in the middle of a decode
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        run_phase(0, 1, 0, 0);
        run_phase(1, 1, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(cn_start_o == 0 && iter_o == 0, "R1 mid-run reset", iter_o, 0);
        chk(done_o == 0 && rd_en_o == 0, "R1 mid-run reset flags", done_o, 0);
        @(negedge clk);
        chk(cn_start_o == 0 && load_start_o == 0, "R1 idle after reset", cn_start_o, 0);

        // R2: a fresh decode after reset still completes
        do_run(0, 1, 0, 0);

        summary();
        $finish;
    end

endmodule